// File: doc/BRIEF.md
# AES Byte-Slice Round Unit

This block is the execution datapath for the four 32-bit scalar AES instructions of a processor core. Each operation takes one byte of the second operand and substitutes it through the forward or inverse AES S-box. In the middle-round variants it then multiplies the substituted byte by one column of the forward or inverse MixColumns matrix. The resulting 32-bit word is rotated so that its lowest byte lands in the lane that was selected, and it is XORed into the first operand. A full AES round on a 128-bit state held as four little-endian column words takes sixteen such operations. Software performs ShiftRows by choosing which column word feeds each step.

The unit is purely combinational, with no clock and no reset, so the result is valid in the same cycle as the operands. Instruction decode, the register file and the sequencing of rounds stay in the surrounding pipeline. Both substitutions share one GF(2^8) inverter: an affine map is applied after it for encryption, or an inverse affine map before it for decryption.

Top module: `aes_bytewise_unit`

## Requirements
- R1: Only byte lane `bs` of `rs2` (bits 8·bs+7 down to 8·bs) reaches the substitution. The other three bytes of `rs2` have no effect on `rd`.
- R2: With `op` = 2'b00 (encrypt-final), `rd` = `rs1` XOR (S(x) shifted left by 8·bs), where x is the selected byte and S is the forward AES S-box.
- R3: With `op` = 2'b10 (decrypt-final), `rd` = `rs1` XOR (Sinv(x) shifted left by 8·bs), where Sinv is the inverse AES S-box.
- R4: With `op` = 2'b01 (encrypt-middle), s = S(x) and the word whose bytes from least to most significant are 2·s, s, s and 3·s is rotated left by 8·bs and XORed into `rs1`.
- R5: With `op` = 2'b11 (decrypt-middle), s = Sinv(x) and the word whose bytes from least to most significant are 0x0E·s, 0x09·s, 0x0D·s and 0x0B·s is rotated left by 8·bs and XORed into `rs1`.
- R6: GF(2^8) doubling shifts left by one and XORs in 0x1B when the top bit of the input was set. For example, 2·0x80 = 0x1B.
- R7: `rd` depends only on the present inputs and settles within the same cycle, without any clock edge.
- R8: The `op` encoding is fixed: bit 1 selects decryption, and bit 0 selects the middle-round column mix.
- R9: Sixteen encrypt-middle operations on the column words, with ShiftRows expressed as the choice of source word, reproduce one full AES-128 round for a published test vector.
- R10: The forward substitution maps 0x00→0x63, 0x01→0x7C, 0x53→0xED and 0xFF→0x16. The inverse maps 0x00→0x52 and 0x63→0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rs1 | input | 32 | Accumulator operand that the contribution is XORed into |
| rs2 | input | 32 | Source word whose selected byte is substituted |
| bs | input | 2 | Byte-lane select; also sets the rotate amount 8·bs |
| op | input | 2 | Operation: bit 1 = decrypt, bit 0 = middle-round mix |
| rd | output | 32 | Result word |

## Verification
Two functions act on the same evaluation: the lane rotation set by `bs` and the column mix set by `op`. A misrouted rotation in a middle-round operation can therefore hide behind a correct coefficient pattern. The bench drives every combination of operation, lane and byte value together, with distinct filler bytes in the unselected lanes of `rs2` and a nonzero `rs1`. Each result is judged against a model that builds its S-box tables by a separate generator walk, so a fault in the lane, the coefficients, the substitution or the accumulate shows up as a mismatch in a specific lane. The sixteen-step round against a published vector then confirms that rotation and mixing compose correctly across all four lanes.

// File: rtl/aes_bu_pkg.sv
// Package aes_bu_pkg
// Shared operation encoding and GF(2^8) arithmetic for the AES byte-slice
// round unit. Assumes the AES field polynomial x^8+x^4+x^3+x+1.
package aes_bu_pkg;

    localparam int BYTE_W = 8;

    // bit 1: decrypt direction, bit 0: apply the column mix
    typedef enum logic [1:0] {
        OP_ENC_FIN = 2'b00,
        OP_ENC_MID = 2'b01,
        OP_DEC_FIN = 2'b10,
        OP_DEC_MID = 2'b11
    } aes_op_e;

    // multiply by x in GF(2^8)
    function automatic logic [7:0] gf_dbl(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1B : 8'h00);
    endfunction

    // general product by shift-and-add
    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] m;
        acc = 8'h00;
        m   = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ m;
            m = gf_dbl(m);
        end
        return acc;
    endfunction

    // multiplicative inverse as a^254; maps zero to zero
    function automatic logic [7:0] gf_inv(input logic [7:0] a);
        logic [7:0] r;
        logic [7:0] p;
        logic [7:0] e;
        r = 8'h01;
        p = a;
        e = 8'hFE;
        for (int i = 0; i < 8; i++) begin
            if (e[i]) r = gf_mul(r, p);
            p = gf_mul(p, p);
        end
        return r;
    endfunction

    function automatic logic [7:0] rol8(input logic [7:0] a, input int n);
        return (a << n) | (a >> (8 - n));
    endfunction

    // affine step that follows the inverse in the forward S-box
    function automatic logic [7:0] fwd_affine(input logic [7:0] b);
        return b ^ rol8(b, 1) ^ rol8(b, 2) ^ rol8(b, 3) ^ rol8(b, 4) ^ 8'h63;
    endfunction

    // affine step that precedes the inverse in the inverse S-box
    function automatic logic [7:0] inv_affine(input logic [7:0] b);
        return rol8(b, 1) ^ rol8(b, 3) ^ rol8(b, 6) ^ 8'h05;
    endfunction

endpackage

// File: rtl/aes_bu_lane_sel.sv
// Module aes_bu_lane_sel
// Picks one byte lane out of a word. Assumes WORD_W is a whole number of
// bytes; lane 0 is the least significant byte.
module aes_bu_lane_sel #(
    parameter int WORD_W = 32,
    localparam int LANES = WORD_W / aes_bu_pkg::BYTE_W,
    localparam int SEL_W = $clog2(LANES)
) (
    input  logic [WORD_W-1:0]               word_i,
    input  logic [SEL_W-1:0]                sel_i,
    output logic [aes_bu_pkg::BYTE_W-1:0]   byte_o
);
    import aes_bu_pkg::*;

    logic [BYTE_W-1:0] lane_q [LANES];

    // split the word into lanes
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_q[g] = word_i[g*BYTE_W +: BYTE_W];
    end

    // index the selected lane
    always_comb begin
        byte_o = lane_q[sel_i];
    end

endmodule

// File: rtl/aes_bu_sbox.sv
// Module aes_bu_sbox
// Forward or inverse AES substitution of one byte, sharing one field
// inverter. Assumes inverse_i is stable with the data (pure combinational).
module aes_bu_sbox (
    input  logic       inverse_i,
    input  logic [7:0] byte_i,
    output logic [7:0] byte_o
);
    import aes_bu_pkg::*;

    logic [7:0] pre_q;
    logic [7:0] inv_q;

    // inverse direction undoes the affine map before inverting
    always_comb begin
        pre_q = inverse_i ? inv_affine(byte_i) : byte_i;
    end

    // shared multiplicative inverse
    always_comb begin
        inv_q = gf_inv(pre_q);
    end

    // forward direction applies the affine map after inverting
    always_comb begin
        byte_o = inverse_i ? inv_q : fwd_affine(inv_q);
    end

endmodule

// File: rtl/aes_bu_mix.sv
// Module aes_bu_mix
// Builds the unrotated contribution word from a substituted byte: one
// MixColumns column for middle rounds, or the bare byte in lane 0 for final
// rounds. Assumes a four-lane (32-bit) word.
module aes_bu_mix #(
    parameter int WORD_W = 32,
    localparam int LANES = WORD_W / aes_bu_pkg::BYTE_W
) (
    input  logic [7:0]        sub_i,
    input  logic              middle_i,
    input  logic              inverse_i,
    output logic [WORD_W-1:0] word_o
);
    import aes_bu_pkg::*;

    logic [7:0] x2_q;
    logic [7:0] x4_q;
    logic [7:0] x8_q;
    logic [7:0] coef_q [LANES];

    // powers of two of the substituted byte
    always_comb begin
        x2_q = gf_dbl(sub_i);
        x4_q = gf_dbl(x2_q);
        x8_q = gf_dbl(x4_q);
    end

    // per-lane products, lane 0 lowest
    always_comb begin
        for (int k = 0; k < LANES; k++) coef_q[k] = 8'h00;
        if (!middle_i) begin
            coef_q[0] = sub_i;
        end else if (!inverse_i) begin
            coef_q[0] = x2_q;
            coef_q[1] = sub_i;
            coef_q[2] = sub_i;
            coef_q[3] = x2_q ^ sub_i;
        end else begin
            coef_q[0] = x8_q ^ x4_q ^ x2_q;
            coef_q[1] = x8_q ^ sub_i;
            coef_q[2] = x8_q ^ x4_q ^ sub_i;
            coef_q[3] = x8_q ^ x2_q ^ sub_i;
        end
    end

    // pack lanes into the output word
    for (genvar g = 0; g < LANES; g++) begin : g_pack
        assign word_o[g*BYTE_W +: BYTE_W] = coef_q[g];
    end

endmodule

// File: rtl/aes_bytewise_unit.sv
// Module aes_bytewise_unit
// Single-cycle datapath for the 32-bit scalar AES round instructions:
// select a byte of rs2, substitute it, optionally mix a column, rotate left
// by 8*bs and XOR into rs1. Combinational; no clock or reset.
module aes_bytewise_unit #(
    parameter int WORD_W = 32,
    localparam int LANES = WORD_W / aes_bu_pkg::BYTE_W,
    localparam int SEL_W = $clog2(LANES)
) (
    input  logic [WORD_W-1:0] rs1,
    input  logic [WORD_W-1:0] rs2,
    input  logic [SEL_W-1:0]  bs,
    input  logic [1:0]        op,
    output logic [WORD_W-1:0] rd
);
    import aes_bu_pkg::*;

    logic [7:0]        sel_byte;
    logic [7:0]        sub_byte;
    logic [WORD_W-1:0] mix_word;
    logic [WORD_W-1:0] rot_word;
    logic              is_dec;
    logic              is_mid;

    // decode the two operation flags
    always_comb begin
        is_dec = op[1];
        is_mid = op[0];
    end

    aes_bu_lane_sel #(.WORD_W(WORD_W)) u_sel (
        .word_i (rs2),
        .sel_i  (bs),
        .byte_o (sel_byte)
    );

    aes_bu_sbox u_sbox (
        .inverse_i (is_dec),
        .byte_i    (sel_byte),
        .byte_o    (sub_byte)
    );

    aes_bu_mix #(.WORD_W(WORD_W)) u_mix (
        .sub_i     (sub_byte),
        .middle_i  (is_mid),
        .inverse_i (is_dec),
        .word_o    (mix_word)
    );

    // rotate left by whole lanes: output lane j takes mix lane (j - bs)
    for (genvar j = 0; j < LANES; j++) begin : g_rot
        localparam logic [SEL_W-1:0] J_IDX = SEL_W'(j);
        logic [SEL_W-1:0] src_idx;
        assign src_idx = J_IDX - bs;
        assign rot_word[j*BYTE_W +: BYTE_W] = mix_word[src_idx*BYTE_W +: BYTE_W];
    end

    // accumulate into the first operand
    always_comb begin
        rd = rs1 ^ rot_word;
    end

endmodule

// File: rtl/aes_bytewise_unit_chk.sv
// Module aes_bytewise_unit_chk
// Checker bound to aes_bytewise_unit. Relates the lanes of rd^rs1 to each
// other, so lane placement and column coefficients are checked without an
// S-box table. Combinational block, so immediate assertions.
module aes_bytewise_unit_chk (
    input logic [31:0] rs1,
    input logic [31:0] rs2,
    input logic [1:0]  bs,
    input logic [1:0]  op,
    input logic [31:0] rd
);
    import aes_bu_pkg::*;

    logic [31:0] diff;
    logic [31:0] keep_mask;
    logic [7:0]  d0, d1, d2, d3;

    function automatic logic [7:0] pick(input logic [31:0] w, input logic [1:0] k);
        return w[k*8 +: 8];
    endfunction

    function automatic logic [7:0] twice(input logic [7:0] a);
        return a[7] ? ((a << 1) ^ 8'h1B) : (a << 1);
    endfunction

    // lanes of the contribution, counted from the selected lane
    always_comb begin
        diff      = rd ^ rs1;
        keep_mask = 32'hFF << (8 * bs);
        d0 = pick(diff, bs);
        d1 = pick(diff, 2'(bs + 2'd1));
        d2 = pick(diff, 2'(bs + 2'd2));
        d3 = pick(diff, 2'(bs + 2'd3));
    end

    // lane relations per operation
    always_comb begin
        if (!op[0]) begin
            p_final_lane_only_r2: assert ((diff & ~keep_mask) == 32'h0)
                else $error("final op touched a lane other than bs");
        end
        if (op == 2'b01) begin
            p_enc_mid_pair_r4: assert (d1 == d2)
                else $error("encrypt-middle unity lanes differ");
            p_enc_mid_dbl_r6: assert (d0 == twice(d1))
                else $error("encrypt-middle doubled lane wrong");
            p_enc_mid_triple_r4: assert (d3 == (d0 ^ d1))
                else $error("encrypt-middle triple lane wrong");
        end
        if (op == 2'b11) begin
            p_dec_mid_four_r5: assert ((d2 ^ d1) == twice(d3 ^ d1))
                else $error("decrypt-middle 0D/09 relation wrong");
            p_dec_mid_two_r5: assert ((d3 ^ d1) == twice(d0 ^ d1 ^ d2 ^ d3))
                else $error("decrypt-middle 0B/09 relation wrong");
        end
    end

endmodule

bind aes_bytewise_unit aes_bytewise_unit_chk u_chk (
    .rs1 (rs1),
    .rs2 (rs2),
    .bs  (bs),
    .op  (op),
    .rd  (rd)
);

// File: tb/aes_bytewise_unit_tb.sv
// Directed bench for aes_bytewise_unit with an independent reference model.
module aes_bytewise_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] rs1 = '0;
    logic [31:0] rs2 = '0;
    logic [1:0]  bs = '0;
    logic [1:0]  op = '0;
    logic [31:0] rd;

    int checks = 0;
    int failures = 0;
    logic [7:0] ref_s  [256];
    logic [7:0] ref_si [256];

    always #10 clk = ~clk;  // 50 MHz

    aes_bytewise_unit u_dut (
        .rs1 (rs1),
        .rs2 (rs2),
        .bs  (bs),
        .op  (op),
        .rd  (rd)
    );

    function automatic logic [7:0] b_xt(input logic [7:0] a);
        return (a & 8'h80) != 0 ? 8'((a << 1) ^ 8'h1B) : 8'(a << 1);
    endfunction

    function automatic logic [7:0] b_mul(input logic [7:0] a, input logic [7:0] c);
        logic [7:0] r;
        logic [7:0] t;
        r = 0;
        t = a;
        for (int i = 0; i < 4; i++) begin
            if (c[i]) r ^= t;
            t = b_xt(t);
        end
        return r;
    endfunction

    function automatic logic [7:0] b_rl(input logic [7:0] a, input int n);
        return 8'((a << n) | (a >> (8 - n)));
    endfunction

    // forward table from the generator-3 walk, inverse by inversion
    task automatic build_tables();
        logic [7:0] p;
        logic [7:0] q;
        p = 8'h01;
        q = 8'h01;
        for (int n = 0; n < 255; n++) begin
            p = p ^ 8'(p << 1) ^ (p[7] ? 8'h1B : 8'h00);
            q = q ^ 8'(q << 1);
            q = q ^ 8'(q << 2);
            q = q ^ 8'(q << 4);
            if (q[7]) q = q ^ 8'h09;
            ref_s[p] = q ^ b_rl(q, 1) ^ b_rl(q, 2) ^ b_rl(q, 3) ^ b_rl(q, 4) ^ 8'h63;
        end
        ref_s[0] = 8'h63;
        for (int i = 0; i < 256; i++) ref_si[ref_s[i]] = 8'(i);
    endtask

    function automatic logic [31:0] model(input logic [31:0] a, input logic [31:0] b,
                                          input logic [1:0] sel, input logic [1:0] o);
        logic [7:0]  x;
        logic [7:0]  s;
        logic [31:0] w;
        int          sh;
        x  = b[sel*8 +: 8];
        s  = o[1] ? ref_si[x] : ref_s[x];
        sh = 8 * int'(sel);
        case (o)
            2'b01:   w = {b_mul(s, 8'h3), s, s, b_mul(s, 8'h2)};
            2'b11:   w = {b_mul(s, 8'hB), b_mul(s, 8'hD), b_mul(s, 8'h9), b_mul(s, 8'hE)};
            default: w = {24'h0, s};
        endcase
        return a ^ ((w << sh) | (w >> (32 - sh)));
    endfunction

    task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [31:0] a, input logic [31:0] b,
                         input logic [1:0] sel, input logic [1:0] o);
        @(posedge clk);
        #1;
        rs1 = a; rs2 = b; bs = sel; op = o;
        @(negedge clk);
    endtask

    // zero operands during reset give S(0) in lane 0
    task automatic t_reset_state();
        @(negedge clk);
        check32("R2 reset-state zero operands", rd, 32'h0000_0063);
    endtask

    task automatic t_known_points();
        apply(0, 32'h00, 0, 2'b00); check32("R10 S(00)", rd, 32'h63);
        apply(0, 32'h01, 0, 2'b00); check32("R10 S(01)", rd, 32'h7C);
        apply(0, 32'h53, 0, 2'b00); check32("R10 S(53)", rd, 32'hED);
        apply(0, 32'hFF, 0, 2'b00); check32("R10 S(FF)", rd, 32'h16);
        apply(0, 32'h00, 0, 2'b10); check32("R3 R10 Sinv(00)", rd, 32'h52);
        apply(0, 32'h6300_0000, 3, 2'b10); check32("R3 R10 Sinv(63) lane3", rd, 32'h0);
    endtask

    task automatic t_lane_ignore();
        logic [31:0] first;
        apply(32'h1234_5678, 32'h00AB_0000, 2, 2'b01);
        first = rd;
        apply(32'h1234_5678, 32'hFFAB_C3D4, 2, 2'b01);
        check32("R1 unselected rs2 lanes ignored", rd, first);
        check32("R1 selected lane value", rd, model(32'h1234_5678, 32'h00AB_0000, 2, 2'b01));
    endtask

    task automatic t_doubling();
        // s = 0x80 forces the reduction: 2s=1B, 3s=9B
        apply(0, {24'h0, ref_si[8'h80]}, 0, 2'b01);
        check32("R6 R4 doubling with reduction", rd, 32'h9B80_801B);
        apply(0, {16'h0, ref_si[8'h80], 8'h0}, 1, 2'b01);
        check32("R4 rotation by one lane", rd, 32'h8080_1B9B);
    endtask

    task automatic t_op_codes();
        apply(32'hA5A5_A5A5, 32'h0000_0011, 0, 2'b00);
        check32("R8 op 00 encrypt-final", rd, 32'hA5A5_A5A5 ^ {24'h0, ref_s[8'h11]});
        apply(32'hA5A5_A5A5, 32'h0000_0011, 0, 2'b10);
        check32("R8 op 10 decrypt-final", rd, 32'hA5A5_A5A5 ^ {24'h0, ref_si[8'h11]});
    endtask

    task automatic t_comb();
        @(negedge clk);
        rs1 = 32'hDEAD_BEEF; rs2 = 32'h0000_5300; bs = 1; op = 2'b00;
        #1;
        check32("R7 result without clock edge", rd, 32'hDEAD_BEEF ^ 32'h0000_ED00);
    endtask

    task automatic t_sweep();
        int bad;
        for (int o = 0; o < 4; o++) begin
            bad = 0;
            for (int sel = 0; sel < 4; sel++) begin
                for (int v = 0; v < 256; v++) begin
                    logic [31:0] a;
                    logic [31:0] b;
                    a = 32'h9E37_79B9 ^ (32'(v) * 32'h0101_0101) ^ 32'(sel << 5);
                    b = 32'h5A3C_96E1 ^ 32'(v * 7 + 1);
                    b[sel*8 +: 8] = 8'(v);
                    apply(a, b, 2'(sel), 2'(o));
                    if (rd !== model(a, b, 2'(sel), 2'(o))) bad++;
                end
            end
            case (o)
                0: check32("R2 sweep encrypt-final mismatches", 32'(bad), 0);
                1: check32("R4 sweep encrypt-middle mismatches", 32'(bad), 0);
                2: check32("R3 sweep decrypt-final mismatches", 32'(bad), 0);
                default: check32("R5 sweep decrypt-middle mismatches", 32'(bad), 0);
            endcase
        end
    endtask

    // one AES-128 middle round from sixteen operations
    task automatic t_round();
        logic [31:0] st [4];
        logic [31:0] rk [4];
        logic [31:0] ex [4];
        logic [31:0] acc;
        st = '{32'hBEE3_3D19, 32'h2BE2_F4A0, 32'h2A8D_C69A, 32'h0848_F8E9};
        rk = '{32'h17FE_FAA0, 32'hB12C_5488, 32'h3939_A323, 32'h0576_6C2A};
        ex = '{32'hF27F_9CA4, 32'h2B35_9F68, 32'h43EA_5B6B, 32'h4950_6A02};
        for (int c = 0; c < 4; c++) begin
            acc = rk[c];
            for (int r = 0; r < 4; r++) begin
                apply(acc, st[(c + r) % 4], 2'(r), 2'b01);
                acc = rd;
            end
            check32("R9 full round column", acc, ex[c]);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        build_tables();
        t_reset_state();
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        t_known_points();
        t_lane_ignore();
        t_doubling();
        t_op_codes();
        t_comb();
        t_round();
        t_sweep();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule